// File: doc/BRIEF.md
# Register-Programmed SPI Master

This block is a single-master SPI engine that software drives through a small word-addressed register bus. Software loads up to eight 32-bit transmit words, writes a bit count minus one into the length register, and then writes the control register with the start bit set. The engine asserts one of its chip-select lines, clocks out between 1 and 256 bits on MOSI, and samples MISO. It places every received bit into the receive bank at the same word and bit position as the transmit bit sent in that slot. When the frame ends it releases chip select and sets a sticky done flag. That flag can drive an interrupt line unless it is masked.

Frames are right-aligned rather than padded. With MSB-first order the first bit on the wire is transmit word 0 at bit (length mod 32). Later bits step down through that word and then through the following words from bit 31 to bit 0. A 24-bit frame therefore occupies the low 24 bits of the first word. In a 32-bit frame that sends an 8-bit command and reads 24 bits, the reply ends up in the low 24 bits of receive word 0. Clock polarity, clock phase, bit order and the target chip select are chosen per transfer. SCLK runs at the system clock divided by the parameter DIV.

Top module: `spi_reg_master`

## Requirements
- R1: After reset all chip-select lines are high, SCLK, MOSI and irq are low, and the control and length registers read zero.
- R2: The bus address is a byte address. Bits [1:0] are ignored. Receive word i reads at 4*i (0x00 to 0x1C). Transmit word i is written and read back at 0x20+4*i. Control is at 0x40 and length is at 0x44. Any other address reads zero, and writes to receive words have no effect.
- R3: A transfer with length value L produces exactly L+1 SCLK cycles (2*(L+1) transitions), spaced DIV/2 system clocks apart, for L from 0 to 255.
- R4: With control bit 3 clear (MSB first), slot k (k = 0 first) carries bit c = L-k of the frame. Bit c lives in transmit word (L>>5)-(c>>5) at bit (c mod 32).
- R5: With control bit 3 set (LSB first), slot k carries frame bit c = k, using the same word and bit mapping as R4.
- R6: The MISO bit sampled in slot k is written to the receive word and bit that R4/R5 give for that slot. Receive bits outside the frame keep their values.
- R7: SCLK idles at control bit 2 (CPOL), and any control write while idle sets that level at once. With control bit 1 (CPHA) clear, the first bit is on MOSI when chip select falls, MISO is sampled on the leading transition, and MOSI changes on the trailing one. With CPHA set, MOSI changes on the leading transition and MISO is sampled on the trailing one.
- R8: Control bits [5:4] pick the single chip-select line driven low. It falls DIV/2 clocks before the first SCLK transition and rises DIV/2 clocks after the last one.
- R9: Writing control with bit 0 set starts a transfer. Control bit 0 reads back as the busy flag, so the start bit is never held. While busy, writes to control and length are ignored.
- R10: Control bit 8 is a sticky done flag. It is set when chip select rises and cleared by the next accepted start. irq is high exactly when done is set and mask bit 9 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, with bus_sel |
| bus_addr | input | 7 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip selects |
| irq | output | 1 | Unmasked transfer-done indication |

## Verification
The assertions assume that DIV is even and at least 2 and that the number of chip selects is a power of two. They also assume that MISO changes only on the shifting SCLK transition, at least one system clock before the engine samples it. The bench's peripheral model changes MISO only in response to a shifting transition it has observed. The bench writes transmit words only while the engine is idle. It tries control and length writes during a transfer only to confirm that they are dropped.

// File: rtl/spi_pkg.sv
package spi_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_TRAIL} seq_state_e;

  typedef struct packed {
    logic lsb;
    logic cpol;
    logic cpha;
  } spi_mode_t;

  localparam int CTL_GO   = 0;
  localparam int CTL_CPHA = 1;
  localparam int CTL_CPOL = 2;
  localparam int CTL_LSB  = 3;
  localparam int CTL_SEL  = 4;
  localparam int CTL_DONE = 8;
  localparam int CTL_MASK = 9;
endpackage

// File: rtl/spi_word_bank.sv
module spi_word_bank #(
  parameter int WORD   = 32,
  parameter int NWORDS = 8,
  localparam int WB = $clog2(WORD),
  localparam int WW = $clog2(NWORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tx_we,
  input  logic [WW-1:0]   tx_widx,
  input  logic [WORD-1:0] tx_wdata,
  input  logic            rx_we,
  input  logic [WW-1:0]   rx_widx,
  input  logic [WB-1:0]   rx_bidx,
  input  logic            rx_bit,
  input  logic            rd_is_tx,
  input  logic [WW-1:0]   rd_idx,
  output logic [WORD-1:0] rd_data,
  input  logic [WW-1:0]   bit_widx,
  input  logic [WB-1:0]   bit_bidx,
  output logic            bit_val
);
  logic [WORD-1:0] tx_all [NWORDS];
  logic [WORD-1:0] rx_all [NWORDS];

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic [WORD-1:0] tx_w, rx_w;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tx_w <= '0;
        rx_w <= '0;
      end else begin
        if (tx_we && tx_widx == WW'(w)) tx_w <= tx_wdata;
        if (rx_we && rx_widx == WW'(w)) rx_w[rx_bidx] <= rx_bit;
      end
    end
    assign tx_all[w] = tx_w;
    assign rx_all[w] = rx_w;
  end

  assign rd_data = rd_is_tx ? tx_all[rd_idx] : rx_all[rd_idx];
  assign bit_val = tx_all[bit_widx][bit_bidx];
endmodule

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int HALF = 2,
  localparam int HCW = (HALF > 1) ? $clog2(HALF) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic tick
);
  logic [HCW-1:0] hcnt_q;

  assign tick = run && (hcnt_q == HCW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hcnt_q <= '0;
    else if (clear)  hcnt_q <= '0;
    else if (run)    hcnt_q <= tick ? '0 : hcnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_frame_seq.sv
module spi_frame_seq
  import spi_pkg::*;
#(
  parameter int WORD   = 32,
  parameter int NWORDS = 8,
  parameter int NSLV   = 4,
  localparam int WB   = $clog2(WORD),
  localparam int WW   = $clog2(NWORDS),
  localparam int CW   = WW + WB,
  localparam int SELW = (NSLV > 1) ? $clog2(NSLV) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic            go,
  input  spi_mode_t       mode,
  input  logic [SELW-1:0] sel,
  input  logic [CW-1:0]   tlen,
  input  logic            tick,
  input  logic            miso,
  input  logic            tx_bit,
  output logic [WW-1:0]   tx_widx,
  output logic [WB-1:0]   tx_bidx,
  output logic            rx_we,
  output logic [WW-1:0]   rx_widx,
  output logic [WB-1:0]   rx_bidx,
  output logic            rx_bit,
  output logic            busy,
  output logic            done,
  output logic            sclk,
  output logic            mosi,
  output logic [NSLV-1:0] cs_n
);
  seq_state_e      state_q;
  logic [CW-1:0]   cur_q, c_next, c_init, rd_c;
  logic [CW:0]     ecnt_q;
  logic            sclk_q, mosi_q, done_q;
  logic [NSLV-1:0] cs_q;
  logic            lead, last;
  logic [WW-1:0]   top;

  assign top    = tlen[CW-1:WB];
  assign lead   = ~ecnt_q[0];
  assign last   = (ecnt_q == {tlen, 1'b1});
  assign c_init = mode.lsb ? '0 : tlen;
  assign c_next = mode.lsb ? cur_q + 1'b1 : cur_q - 1'b1;

  always_comb begin
    if (state_q == ST_IDLE)  rd_c = c_init;
    else if (!mode.cpha)     rd_c = c_next;
    else                     rd_c = cur_q;
  end

  assign tx_widx = top - rd_c[CW-1:WB];
  assign tx_bidx = rd_c[WB-1:0];

  assign rx_we   = (state_q == ST_SHIFT) && tick && (lead ^ mode.cpha);
  assign rx_widx = top - cur_q[CW-1:WB];
  assign rx_bidx = cur_q[WB-1:0];
  assign rx_bit  = miso;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      ecnt_q  <= '0;
      sclk_q  <= 1'b0;
      mosi_q  <= 1'b0;
      done_q  <= 1'b0;
      cs_q    <= '1;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (cfg_we) sclk_q <= mode.cpol;
          if (go) begin
            state_q <= ST_SHIFT;
            cur_q   <= c_init;
            ecnt_q  <= '0;
            mosi_q  <= tx_bit;
            done_q  <= 1'b0;
            cs_q    <= ~(NSLV'(1) << sel);
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            sclk_q <= ~sclk_q;
            ecnt_q <= ecnt_q + 1'b1;
            if (lead) begin
              if (mode.cpha) mosi_q <= tx_bit;
            end else begin
              cur_q <= c_next;
              if (!mode.cpha && !last) mosi_q <= tx_bit;
            end
            if (last) state_q <= ST_TRAIL;
          end
        end
        default: begin
          if (tick) begin
            cs_q    <= '1;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign done = done_q;
  assign sclk = sclk_q;
  assign mosi = mosi_q;
  assign cs_n = cs_q;
endmodule

// File: rtl/spi_reg_master.sv
module spi_reg_master
  import spi_pkg::*;
#(
  parameter int DIV    = 4,
  parameter int NWORDS = 8,
  parameter int WORD   = 32,
  parameter int NSLV   = 4,
  localparam int AW = $clog2(NWORDS * 8 + 8)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [WORD-1:0] bus_wdata,
  output logic [WORD-1:0] bus_rdata,
  output logic            sclk,
  output logic            mosi,
  input  logic            miso,
  output logic [NSLV-1:0] cs_n,
  output logic            irq
);
  localparam int HALF = DIV / 2;
  localparam int WB   = $clog2(WORD);
  localparam int WW   = $clog2(NWORDS);
  localparam int CW   = WW + WB;
  localparam int SELW = (NSLV > 1) ? $clog2(NSLV) : 1;
  localparam int IXW  = AW - 2;

  logic [IXW-1:0] widx;
  logic is_rx, is_tx, is_ctl, is_len;
  logic ctl_wr_raw, cfg_we, go;
  logic busy_w, done_w, tick;

  spi_mode_t       mode_q, mode_eff;
  logic [SELW-1:0] sel_q, sel_eff;
  logic            mask_q;
  logic [CW-1:0]   tlen_q;

  logic [WORD-1:0] bank_word;
  logic [WW-1:0]   tx_widx, rx_widx;
  logic [WB-1:0]   tx_bidx, rx_bidx;
  logic            tx_bit, rx_we, rx_bit;

  assign widx   = bus_addr[AW-1:2];
  assign is_rx  = widx < IXW'(NWORDS);
  assign is_tx  = (widx >= IXW'(NWORDS)) && (widx < IXW'(2 * NWORDS));
  assign is_ctl = widx == IXW'(2 * NWORDS);
  assign is_len = widx == IXW'(2 * NWORDS + 1);

  assign ctl_wr_raw = bus_sel && bus_we && is_ctl;
  assign cfg_we     = ctl_wr_raw && !busy_w;
  assign go         = cfg_we && bus_wdata[CTL_GO];

  always_comb begin
    mode_eff = mode_q;
    sel_eff  = sel_q;
    if (cfg_we) begin
      mode_eff.lsb  = bus_wdata[CTL_LSB];
      mode_eff.cpol = bus_wdata[CTL_CPOL];
      mode_eff.cpha = bus_wdata[CTL_CPHA];
      sel_eff       = bus_wdata[CTL_SEL +: SELW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      sel_q  <= '0;
      mask_q <= 1'b0;
      tlen_q <= '0;
    end else begin
      if (cfg_we) begin
        mode_q <= mode_eff;
        sel_q  <= sel_eff;
        mask_q <= bus_wdata[CTL_MASK];
      end
      if (bus_sel && bus_we && is_len && !busy_w) tlen_q <= bus_wdata[CW-1:0];
    end
  end

  spi_word_bank #(.WORD(WORD), .NWORDS(NWORDS)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_we    (bus_sel && bus_we && is_tx),
    .tx_widx  (widx[WW-1:0]),
    .tx_wdata (bus_wdata),
    .rx_we    (rx_we),
    .rx_widx  (rx_widx),
    .rx_bidx  (rx_bidx),
    .rx_bit   (rx_bit),
    .rd_is_tx (is_tx),
    .rd_idx   (widx[WW-1:0]),
    .rd_data  (bank_word),
    .bit_widx (tx_widx),
    .bit_bidx (tx_bidx),
    .bit_val  (tx_bit)
  );

  spi_half_timer #(.HALF(HALF)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (go),
    .run   (busy_w),
    .tick  (tick)
  );

  spi_frame_seq #(.WORD(WORD), .NWORDS(NWORDS), .NSLV(NSLV)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_we  (cfg_we),
    .go      (go),
    .mode    (mode_eff),
    .sel     (sel_eff),
    .tlen    (tlen_q),
    .tick    (tick),
    .miso    (miso),
    .tx_bit  (tx_bit),
    .tx_widx (tx_widx),
    .tx_bidx (tx_bidx),
    .rx_we   (rx_we),
    .rx_widx (rx_widx),
    .rx_bidx (rx_bidx),
    .rx_bit  (rx_bit),
    .busy    (busy_w),
    .done    (done_w),
    .sclk    (sclk),
    .mosi    (mosi),
    .cs_n    (cs_n)
  );

  always_comb begin
    bus_rdata = '0;
    if (is_rx || is_tx) begin
      bus_rdata = bank_word;
    end else if (is_ctl) begin
      bus_rdata[CTL_GO]           = busy_w;
      bus_rdata[CTL_CPHA]         = mode_q.cpha;
      bus_rdata[CTL_CPOL]         = mode_q.cpol;
      bus_rdata[CTL_LSB]          = mode_q.lsb;
      bus_rdata[CTL_SEL +: SELW]  = sel_q;
      bus_rdata[CTL_DONE]         = done_w;
      bus_rdata[CTL_MASK]         = mask_q;
    end else if (is_len) begin
      bus_rdata[CW-1:0] = tlen_q;
    end
  end

  assign irq = done_w && !mask_q;
endmodule

// File: rtl/spi_reg_master_chk.sv
module spi_reg_master_chk #(
  parameter int NSLV = 4,
  parameter int CW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSLV-1:0] cs_n,
  input logic            sclk,
  input logic            ctl_wr,
  input logic            busy,
  input logic            done,
  input logic            irq,
  input logic [CW-1:0]   tlen
);
  // R8
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R7
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&cs_n && !ctl_wr) |=> $stable(sclk));

  // R10
  done_at_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $rose(&cs_n));

  // R10
  irq_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done);

  // R9
  len_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(tlen));

  // R9
  done_clear_by_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(ctl_wr));
endmodule

bind spi_reg_master spi_reg_master_chk #(.NSLV(NSLV), .CW(CW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .cs_n   (cs_n),
  .sclk   (sclk),
  .ctl_wr (ctl_wr_raw),
  .busy   (busy_w),
  .done   (done_w),
  .irq    (irq),
  .tlen   (tlen_q)
);

// File: tb/test_spi_reg_master.sv
module test_spi_reg_master;
  localparam int DIV  = 4;
  localparam int HALF = DIV / 2;
  localparam int NW   = 8;
  localparam int NS   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        sclk, mosi, irq;
  logic        miso = 1'b0;
  logic [NS-1:0] cs_n;
  wire         all_hi = &cs_n;

  always #2 clk = ~clk;

  spi_reg_master #(.DIV(DIV), .NWORDS(NW), .WORD(32), .NSLV(NS)) i_spi_reg_master (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n), .irq(irq)
  );

  int checks = 0, fails = 0;
  int cyc = 0;
  bit t_cpol, t_cpha;
  bit sb [256];
  bit got [256];
  int rk, sk, ntr, t_fall, t_first, t_last, t_rise;
  logic [NS-1:0] low_line;
  logic [31:0] rxm [NW];
  bit lead;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 7'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 7'(a);
    #1 d = bus_rdata;
  endtask

  always @(negedge clk) cyc++;

  // peripheral model
  always @(negedge all_hi) begin
    t_fall = cyc; rk = 0; sk = 0; ntr = 0; low_line = cs_n;
    if (!t_cpha) miso = sb[0];
  end
  always @(posedge all_hi) t_rise = cyc;
  always @(sclk) begin
    if (all_hi === 1'b0) begin
      ntr++;
      if (ntr == 1) t_first = cyc;
      t_last = cyc;
      lead = (sclk != t_cpol);
      if (lead ^ t_cpha) begin
        if (rk < 256) got[rk] = mosi;
        rk++;
      end else if (t_cpha) begin
        if (sk < 256) miso = sb[sk];
        sk++;
      end else begin
        sk++;
        if (sk < 256) miso = sb[sk];
      end
    end
  end

  task automatic xfer(input bit cpol, input bit cpha, input bit lsb,
                      input int sel, input int tl, input bit mask, input bit poke);
    logic [31:0] txw [NW];
    logic [31:0] ctl, rv;
    int n, top, bad, c, wd, bt;
    for (int w = 0; w < NW; w++) begin
      txw[w] = $urandom;
      wr(32'h20 + 4 * w, txw[w]);
    end
    for (int k = 0; k < 256; k++) sb[k] = 1'($urandom_range(1, 0));
    wr(32'h44, 32'(tl));
    ctl = (32'(mask) << 9) | (32'(sel) << 4) | (32'(lsb) << 3) |
          (32'(cpol) << 2) | (32'(cpha) << 1);
    wr(32'h40, ctl);
    @(negedge clk);
    chk(sclk == cpol, "R7", "idle sclk after mode write", sclk, cpol);
    t_cpol = cpol; t_cpha = cpha;
    wr(32'h40, ctl | 32'h1);
    rd(32'h40, rv);
    // R9 busy reads 1, R10 done cleared by start
    chk(rv[0] == 1'b1 && rv[8] == 1'b0, "R9", "busy/done after start", rv, ctl | 32'h1);
    if (poke) begin
      repeat (20) @(negedge clk);
      wr(32'h44, 32'd5);
      wr(32'h40, ctl ^ 32'h7);
    end
    wait (all_hi == 1'b1);
    repeat (2) @(negedge clk);

    n = tl + 1; top = tl >> 5; bad = 0;
    for (int k = 0; k < n; k++) begin
      c  = lsb ? k : tl - k;
      wd = top - (c >> 5);
      bt = c % 32;
      if (got[k] != txw[wd][bt]) bad++;
      rxm[wd][bt] = sb[k];
    end
    chk(bad == 0, lsb ? "R5" : "R4", "mosi bit mismatches", bad, 0);
    chk(ntr == 2 * n, "R3", "sclk transitions", ntr, 2 * n);
    chk(t_last - t_first == (2 * n - 1) * HALF, "R3", "sclk span", t_last - t_first, (2 * n - 1) * HALF);
    chk(t_first - t_fall == HALF, "R8", "cs lead", t_first - t_fall, HALF);
    chk(t_rise - t_last == HALF, "R8", "cs trail", t_rise - t_last, HALF);
    chk(low_line == ~(4'(1) << sel), "R8", "selected line", low_line, ~(4'(1) << sel));
    chk(sclk == cpol, "R7", "sclk idle after frame", sclk, cpol);
    for (int w = 0; w < NW; w++) begin
      rd(4 * w, rv);
      chk(rv == rxm[w], "R6", "rx word", rv, rxm[w]);
    end
    rd(32'h40, rv);
    chk(rv == (ctl | 32'h100), "R10", "control after done", rv, ctl | 32'h100);
    chk(irq == !mask, "R10", "irq vs mask", irq, !mask);
    if (poke) begin
      rd(32'h44, rv);
      chk(rv == 32'(tl), "R9", "length write while busy", rv, tl);
    end
  endtask

  initial begin
    logic [31:0] rv;
    int lens [7] = '{0, 6, 23, 31, 32, 62, 255};
    for (int w = 0; w < NW; w++) rxm[w] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(cs_n == '1, "R1", "cs_n at reset", cs_n, 4'hf);
    chk(sclk == 1'b0 && mosi == 1'b0 && irq == 1'b0, "R1", "sclk/mosi/irq", {sclk, mosi, irq}, 0);
    rd(32'h40, rv); chk(rv == 0, "R1", "control at reset", rv, 0);
    rd(32'h44, rv); chk(rv == 0, "R1", "length at reset", rv, 0);
    // R2
    wr(32'h2C, 32'hA5C3_0F96);
    rd(32'h2C, rv); chk(rv == 32'hA5C3_0F96, "R2", "tx3 readback", rv, 32'hA5C3_0F96);
    wr(32'h25, 32'h1234_5678);
    rd(32'h24, rv); chk(rv == 32'h1234_5678, "R2", "low address bits ignored", rv, 32'h1234_5678);
    wr(32'h04, 32'hFFFF_FFFF);
    rd(32'h04, rv); chk(rv == 32'h0, "R2", "rx write ignored", rv, 0);
    rd(32'h48, rv); chk(rv == 32'h0, "R2", "unmapped reads zero", rv, 0);
    wr(32'h44, 32'd23);
    rd(32'h44, rv); chk(rv == 32'd23, "R2", "length readback", rv, 23);

    for (int m = 0; m < 8; m++) begin
      for (int li = 0; li < 7; li++) begin
        xfer(1'(m >> 2), 1'(m >> 1), 1'(m), (li + m) % NS, lens[li], 1'(li % 2), lens[li] == 255);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R3 watchdog expired actual=0x%0h expected=0x%0h", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule